// File: doc/BRIEF.md
# Memory Queue Address Updater

This block keeps the address registers of five memory access queues and moves each one by a word after every access, so that a core can walk a buffer or a stack without spending instructions on pointer arithmetic. Each queue has a strobe that marks an access in the current cycle. The block gives back the effective address of that access at once, without a register in the path. The new pointer value is stored at the next clock edge. How each pointer moves is set by fields in a control word. The block keeps its own copy of that word, so the word can be read and written in every cycle.

The last two queues can also act as stacks. When their stack bit is set, the pointer is changed before the access and the effective address is the changed value. A write port lets software load any queue pointer directly. That load wins over an automatic update in the same cycle.

Top module: `mq_addr_unit`

## Requirements
- R1: After a synchronous active-low reset, all five queue addresses and the control word read as zero.
- R2: Queue k (k = 0..4) is driven by control bits [2k+1:2k]. Bit 2k+1 enables updating and bit 2k selects the direction, so code 10 adds 4 to the queue address on a strobe and code 11 subtracts 4.
- R3: Codes 00 and 01 leave the queue address unchanged on a strobe, and the effective address equals the current address.
- R4: With stack mode off, a strobe gives the effective address as the current (old) address, and the register holds the stepped value from the next cycle on.
- R5: Control bit 10 sets stack mode for queue 3 and bit 11 sets it for queue 4. In stack mode a strobe gives the stepped value as the effective address, and the register takes that same value.
- R6: Control bits 31..12 always read as zero and ignore writes. Bits 10 and 11 have no effect on queues 0 to 2.
- R7: With addr_we high, addr_wdata is loaded into the queue chosen by addr_wsel. This load wins over a strobe on the same queue in the same cycle. Select values 5 to 7 change nothing.
- R8: A queue with no strobe and no load keeps its address. Strobes on different queues in the same cycle each act on their own queue.
- R9: Stepping wraps modulo 2^32 (0 minus 4 gives FFFFFFFC, FFFFFFFC plus 4 gives 0).
- R10: A control word write takes effect from the next cycle. A strobe in the same cycle as the write uses the old word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctrl_we | input | 1 | Control word write enable |
| ctrl_wdata | input | 32 | Control word write data |
| ctrl_rdata | output | 32 | Control word readback |
| acc_strobe | input | 5 | Per-queue access strobe, bit k for queue k |
| addr_we | input | 1 | Queue address load enable |
| addr_wsel | input | 3 | Queue selected for the load |
| addr_wdata | input | 32 | Queue address load data |
| eff_addr | output | 160 | Effective address for each queue, queue k at bits [32k+31:32k] |
| q_addr | output | 160 | Current queue addresses, queue k at bits [32k+31:32k] |

## Verification
Each stepping mode is tried from a freshly loaded start address. Pairing the effective address with the next stored value separates post-modify from pre-modify, and separates increment from decrement and from the two no-update codes. Start values at 0 and FFFFFFFC expose a missing wrap. Setting the stack bits on a queue without stack support shows whether the stack control leaks into other queues. Cycles that combine a strobe with a load, or with a control write, show whether the priority and the one-cycle control latency are right. A strobe on all queues at once shows whether the lanes are independent.

// File: rtl/mq_pkg.sv
// Shared types for the memory queue address updater.
// Assumes nothing beyond a common per-queue mode record.
package mq_pkg;

    // Per-queue stepping controls decoded from the control word
    typedef struct packed {
        logic en;    // update on access
        logic down;  // 1: subtract step, 0: add step
        logic stk;   // pre-modify (stack) instead of post-modify
    } mq_mode_t;

endpackage

// File: rtl/mq_ctrl_reg.sv
// Control word shadow register for the queue updater.
// Holds only the implemented bits (2 per queue plus one stack bit for
// each of the last NUM_STK queues); all other bits read as zero.
// Assumes 2*NUM_Q+NUM_STK <= CTRL_W.
module mq_ctrl_reg
    import mq_pkg::*;
#(
    parameter int CTRL_W  = 32,
    parameter int NUM_Q   = 5,
    parameter int NUM_STK = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [CTRL_W-1:0] wdata_i,
    output logic [CTRL_W-1:0] rdata_o,
    output mq_mode_t          mode_o [NUM_Q]
);

    localparam int USED_W    = 2 * NUM_Q + NUM_STK;
    localparam int FIRST_STK = NUM_Q - NUM_STK;
    localparam logic [CTRL_W-1:0] USED_MASK = CTRL_W'((64'd1 << USED_W) - 64'd1);

    logic [CTRL_W-1:0] ctrl_q;

    // Store the writable bits; unimplemented bits are dropped on write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (we_i) begin
            ctrl_q <= wdata_i & USED_MASK;
        end
    end

    assign rdata_o = ctrl_q;

    // Decode one mode record per queue
    for (genvar k = 0; k < NUM_Q; k++) begin : g_mode
        assign mode_o[k].en   = ctrl_q[2*k+1];
        assign mode_o[k].down = ctrl_q[2*k];
        if (k >= FIRST_STK) begin : g_stk
            assign mode_o[k].stk = ctrl_q[2*NUM_Q + k - FIRST_STK];
        end else begin : g_nostk
            assign mode_o[k].stk = 1'b0;
        end
    end

    // Unimplemented bits never hold a one
    assert_unused_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q & ~USED_MASK) == '0);

    // A write is visible, masked, on the next cycle
    assert_ctrl_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> ctrl_q == ($past(wdata_i) & USED_MASK));

endmodule

// File: rtl/mq_lane.sv
// One queue pointer: holds the address, forms the effective address of
// an access and stores the stepped value after it.
// Assumes the mode record is stable through the cycle of the strobe.
// A direct load has priority over an automatic update.
module mq_lane
    import mq_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int STEP_BYTES = 4,
    parameter bit HAS_STK    = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  mq_mode_t          mode_i,
    input  logic              acc_i,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] wr_data_i,
    output logic [ADDR_W-1:0] eff_o,
    output logic [ADDR_W-1:0] addr_o
);

    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(STEP_BYTES);

    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] stepped;
    logic              pre_mod;

    // Next pointer value for an access under the current mode
    always_comb begin
        stepped = addr_q;
        if (mode_i.en) begin
            stepped = mode_i.down ? (addr_q - STEP) : (addr_q + STEP);
        end
    end

    // Stack mode exists only on lanes built with it
    assign pre_mod = HAS_STK && mode_i.stk;

    // Effective address: modified value in stack mode, old value otherwise
    assign eff_o  = pre_mod ? stepped : addr_q;
    assign addr_o = addr_q;

    // Pointer register: load wins, then access update, else hold
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (wr_i) begin
            addr_q <= wr_data_i;
        end else if (acc_i) begin
            addr_q <= stepped;
        end
    end

    // Idle lane keeps its pointer
    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_i && !wr_i) |=> addr_q == $past(addr_q));

    // Direct load overrides everything
    assert_load_prio_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> addr_q == $past(wr_data_i));

    // Enabled access moves the pointer by one step in the chosen direction
    assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_i && !wr_i && mode_i.en) |=>
        addr_q == ($past(mode_i.down) ? $past(addr_q) - STEP : $past(addr_q) + STEP));

    // Disabled update leaves the pointer alone on access
    assert_no_update_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_i && !wr_i && !mode_i.en) |=> addr_q == $past(addr_q));

    // Pre-modify: the stored pointer equals the address just used
    assert_pre_mod_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_i && !wr_i && pre_mod) |=> addr_q == $past(eff_o));

    // Post-modify: the address used is the pointer before the update
    assert_post_mod_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_i && !wr_i && !pre_mod) |=> $past(eff_o) == $past(addr_q));

endmodule

// File: rtl/mq_addr_unit.sv
// Memory queue address updater: NUM_Q queue pointers with automatic
// step after each access, controlled by a shadowed control word.
// The last NUM_STK queues support pre-modify (stack) addressing.
// Assumes at most one load per cycle through the single write port.
module mq_addr_unit
    import mq_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int NUM_Q      = 5,
    parameter int NUM_STK    = 2,
    parameter int STEP_BYTES = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      ctrl_we,
    input  logic [ADDR_W-1:0]         ctrl_wdata,
    output logic [ADDR_W-1:0]         ctrl_rdata,
    input  logic [NUM_Q-1:0]          acc_strobe,
    input  logic                      addr_we,
    input  logic [$clog2(NUM_Q)-1:0]  addr_wsel,
    input  logic [ADDR_W-1:0]         addr_wdata,
    output logic [NUM_Q*ADDR_W-1:0]   eff_addr,
    output logic [NUM_Q*ADDR_W-1:0]   q_addr
);

    localparam int SEL_W     = $clog2(NUM_Q);
    localparam int FIRST_STK = NUM_Q - NUM_STK;

    mq_mode_t         mode [NUM_Q];
    logic [NUM_Q-1:0] wr_hit;

    // Control word shadow and mode decode
    mq_ctrl_reg #(
        .CTRL_W  (ADDR_W),
        .NUM_Q   (NUM_Q),
        .NUM_STK (NUM_STK)
    ) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (ctrl_we),
        .wdata_i (ctrl_wdata),
        .rdata_o (ctrl_rdata),
        .mode_o  (mode)
    );

    // One pointer lane per queue; stack support only on the last ones
    for (genvar k = 0; k < NUM_Q; k++) begin : g_lane
        assign wr_hit[k] = addr_we && (addr_wsel == SEL_W'(k));

        mq_lane #(
            .ADDR_W     (ADDR_W),
            .STEP_BYTES (STEP_BYTES),
            .HAS_STK    (k >= FIRST_STK)
        ) u_lane (
            .clk       (clk),
            .rst_n     (rst_n),
            .mode_i    (mode[k]),
            .acc_i     (acc_strobe[k]),
            .wr_i      (wr_hit[k]),
            .wr_data_i (addr_wdata),
            .eff_o     (eff_addr[k*ADDR_W +: ADDR_W]),
            .addr_o    (q_addr[k*ADDR_W +: ADDR_W])
        );
    end

    // At most one lane is loaded per cycle
    assert_one_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_hit));

endmodule

// File: tb/mq_addr_unit_test.sv
// Self-checking bench for mq_addr_unit: table of single-queue access
// vectors, then directed tests for reset, priority and corner cases.
module mq_addr_unit_test;

    localparam int AW = 32;
    localparam int NQ = 5;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           ctrl_we = 1'b0;
    logic [AW-1:0]  ctrl_wdata = '0;
    logic [AW-1:0]  ctrl_rdata;
    logic [NQ-1:0]  acc_strobe = '0;
    logic           addr_we = 1'b0;
    logic [2:0]     addr_wsel = '0;
    logic [AW-1:0]  addr_wdata = '0;
    logic [NQ*AW-1:0] eff_addr;
    logic [NQ*AW-1:0] q_addr;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    mq_addr_unit uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_we    (ctrl_we),
        .ctrl_wdata (ctrl_wdata),
        .ctrl_rdata (ctrl_rdata),
        .acc_strobe (acc_strobe),
        .addr_we    (addr_we),
        .addr_wsel  (addr_wsel),
        .addr_wdata (addr_wdata),
        .eff_addr   (eff_addr),
        .q_addr     (q_addr)
    );

    typedef struct packed {
        logic [31:0] ctrl;
        logic [2:0]  idx;
        logic [31:0] start;
        logic [31:0] eff;
        logic [31:0] nxt;
    } vec_t;

    // ctrl word, queue, start address, expected effective, expected next
    localparam vec_t VEC [12] = '{
        '{32'h0000_0002, 3'd0, 32'h0000_0100, 32'h0000_0100, 32'h0000_0104}, // R2 R4 q0 post-inc
        '{32'h0000_000C, 3'd1, 32'h0000_0200, 32'h0000_0200, 32'h0000_01FC}, // R2 R4 q1 post-dec
        '{32'h0000_0010, 3'd2, 32'h0000_0300, 32'h0000_0300, 32'h0000_0300}, // R3 code 01
        '{32'h0000_0000, 3'd3, 32'h0000_0400, 32'h0000_0400, 32'h0000_0400}, // R3 code 00
        '{32'h0000_0480, 3'd3, 32'h0000_0500, 32'h0000_0504, 32'h0000_0504}, // R5 q3 pre-inc
        '{32'h0000_0B00, 3'd4, 32'h0000_0600, 32'h0000_05FC, 32'h0000_05FC}, // R5 q4 pre-dec
        '{32'h0000_0300, 3'd4, 32'h0000_0700, 32'h0000_0700, 32'h0000_06FC}, // R4 q4 post-dec
        '{32'h0000_0C02, 3'd0, 32'h0000_0010, 32'h0000_0010, 32'h0000_0014}, // R6 stack bits ignored by q0
        '{32'h0000_0030, 3'd2, 32'h0000_0000, 32'h0000_0000, 32'hFFFF_FFFC}, // R9 wrap down
        '{32'h0000_0080, 3'd3, 32'hFFFF_FFFC, 32'hFFFF_FFFC, 32'h0000_0000}, // R9 wrap up
        '{32'h0000_0400, 3'd3, 32'h0000_0800, 32'h0000_0800, 32'h0000_0800}, // R3 R5 stack without update
        '{32'h0000_0008, 3'd1, 32'h0000_0040, 32'h0000_0040, 32'h0000_0044}  // R2 q1 post-inc
    };

    function automatic logic [31:0] qa(int k);
        return q_addr[k*AW +: AW];
    endfunction

    function automatic logic [31:0] ea(int k);
        return eff_addr[k*AW +: AW];
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic idle();
        ctrl_we = 1'b0;
        addr_we = 1'b0;
        acc_strobe = '0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] snap [NQ];

        // R1: reset state
        repeat (3) step();
        rst_n = 1'b1;
        step();
        chk("R1 ctrl after reset", ctrl_rdata, 32'h0);
        for (int k = 0; k < NQ; k++) chk("R1 queue after reset", qa(k), 32'h0);

        // Table walk
        for (int i = 0; i < 12; i++) begin
            ctrl_we = 1'b1;
            ctrl_wdata = VEC[i].ctrl;
            addr_we = 1'b1;
            addr_wsel = VEC[i].idx;
            addr_wdata = VEC[i].start;
            step();
            idle();
            acc_strobe[VEC[i].idx] = 1'b1;
            #1;
            chk($sformatf("table %0d eff", i), ea(int'(VEC[i].idx)), VEC[i].eff);
            step();
            idle();
            chk($sformatf("table %0d next", i), qa(int'(VEC[i].idx)), VEC[i].nxt);
        end

        // R6: unimplemented control bits read zero
        ctrl_we = 1'b1;
        ctrl_wdata = 32'hFFFF_FFFF;
        step();
        idle();
        chk("R6 ctrl readback masked", ctrl_rdata, 32'h0000_0FFF);

        // R10: control write and strobe in one cycle use the old word
        ctrl_we = 1'b1;
        ctrl_wdata = 32'h0;
        addr_we = 1'b1;
        addr_wsel = 3'd0;
        addr_wdata = 32'h0000_0050;
        step();
        idle();
        ctrl_we = 1'b1;
        ctrl_wdata = 32'h0000_0002;
        acc_strobe[0] = 1'b1;
        step();
        idle();
        chk("R10 old ctrl used", qa(0), 32'h0000_0050);
        chk("R10 new ctrl visible", ctrl_rdata, 32'h0000_0002);
        acc_strobe[0] = 1'b1;
        step();
        idle();
        chk("R10 new ctrl applied", qa(0), 32'h0000_0054);

        // R7: load wins over a strobe on the same queue
        acc_strobe[0] = 1'b1;
        addr_we = 1'b1;
        addr_wsel = 3'd0;
        addr_wdata = 32'h0000_0999;
        step();
        idle();
        chk("R7 load priority", qa(0), 32'h0000_0999);

        // R7: out-of-range select changes nothing
        for (int k = 0; k < NQ; k++) snap[k] = qa(k);
        addr_we = 1'b1;
        addr_wsel = 3'd5;
        addr_wdata = 32'h0000_DEAD;
        step();
        addr_wsel = 3'd7;
        step();
        idle();
        for (int k = 0; k < NQ; k++) chk("R7 bad select ignored", qa(k), snap[k]);

        // R8: all queues post-increment together
        ctrl_we = 1'b1;
        ctrl_wdata = 32'h0000_02AA;
        for (int k = 0; k < NQ; k++) begin
            addr_we = 1'b1;
            addr_wsel = 3'(k);
            addr_wdata = 32'(k) * 32'h1000;
            step();
            ctrl_we = 1'b0;
        end
        idle();
        acc_strobe = '1;
        #1;
        for (int k = 0; k < NQ; k++) chk("R8 parallel eff", ea(k), 32'(k) * 32'h1000);
        step();
        idle();
        for (int k = 0; k < NQ; k++) chk("R8 parallel next", qa(k), 32'(k) * 32'h1000 + 32'd4);

        // R8: no strobe holds every queue
        step();
        for (int k = 0; k < NQ; k++) chk("R8 idle hold", qa(k), 32'(k) * 32'h1000 + 32'd4);

        finish_run();
    end

endmodule